// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a capture/compare array that sits beside a shared 16-bit up/down timer. In capture mode the channel waits for a selected trigger and then copies the current timer count, together with the count direction, into its data register and raises its flag. The trigger can come from an external pin, an overflow pulse from either of two auxiliary timers, or a comparator event. Pin edges are accepted only after the new level has held for two consecutive samples, and the edge polarity is selectable.

In compare mode the data register is compared with the timer on every clock. A match raises the flag and, if enabled, drives a request that makes the timer return to zero. Compare values written over the register bus first land in a shadow register and only reach the active register when the timer overflows, so a running period is never cut short by a half-finished update. The flag is sticky until cleared by software, and an interrupt line follows the flag when enabled.

Top module: `tcc_channel`

## Requirements
- R1: The capture pin counts as changed only after its new level has been seen on two consecutive clock samples; a level held for one cycle only is ignored. With the trigger on the pin, the data register updates on the third rising clock edge after the pin changes.
- R2: `edge_sel` picks the pin edge that triggers: 2'b00 none, 2'b01 falling, 2'b10 rising, 2'b11 both. An edge of the unselected polarity causes no capture.
- R3: `trig_sel` picks the capture source: 2'b00 pin, 2'b01 auxiliary timer 0 overflow, 2'b10 auxiliary timer 1 overflow, 2'b11 comparator event. Pulses on unselected sources cause no capture.
- R4: In capture mode (`mode_cmp` = 0), a trigger pulse present in a cycle copies `timer_cnt` of that cycle into the data register and sets the flag at the next rising edge.
- R5: On capture, the direction bit takes `timer_dir` (0 up, 1 down) when `timer_dual` is 1, and 0 otherwise.
- R6: A capture overwrites the data register even if the flag from the previous capture is still set.
- R7: In compare mode (`mode_cmp` = 1), the flag is set at the rising edge after a cycle in which the data register equals `timer_cnt`.
- R8: `timer_clr_req` is 1 in the same cycle as a compare match when `clr_en` is 1, and 0 otherwise.
- R9: The flag stays set until `flag_clr` is 1; if a new flag-setting event occurs in the same cycle as `flag_clr`, the flag remains set.
- R10: `irq` is 1 exactly when the flag is 1 and `irq_en` is 1.
- R11: In compare mode, a bus write updates only the shadow; the data register takes the shadow value at the edge ending a cycle with `timer_ovf` = 1 and is otherwise unchanged.
- R12: In capture mode a bus write updates the data register at the next edge, but a capture in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_cnt | input | 16 | Current shared timer count |
| timer_dir | input | 1 | Timer count direction, 0 up, 1 down |
| timer_dual | input | 1 | Timer is in dual-slope mode |
| timer_ovf | input | 1 | Timer overflow pulse, loads shadow into active compare value |
| cap_pin | input | 1 | External capture pin |
| aux0_ovf | input | 1 | Overflow pulse of auxiliary timer 0 |
| aux1_ovf | input | 1 | Overflow pulse of auxiliary timer 1 |
| cmp_evt | input | 1 | Comparator event pulse |
| mode_cmp | input | 1 | 0 capture mode, 1 compare mode |
| trig_sel | input | 2 | Capture source select |
| edge_sel | input | 2 | Pin edge polarity select |
| clr_en | input | 1 | Enable timer clear request on compare match |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Bus write strobe for the data register |
| wr_data | input | 16 | Bus write value |
| flag_clr | input | 1 | Clear the channel flag |
| data_out | output | 16 | Active data register |
| dir_out | output | 1 | Captured direction bit |
| flag | output | 1 | Channel flag |
| irq | output | 1 | Interrupt request |
| timer_clr_req | output | 1 | Request to reset the timer to zero |

## Verification
Pin captures are tried with a rising edge, a falling edge under each polarity setting and a one-cycle glitch, which separates a correct two-sample filter from a one-sample one and a wrong polarity decode. Each non-pin source is pulsed both when selected and when not, with the timer in and out of dual-slope mode, telling a wrong source decode from a wrong direction latch. Compare runs put the timer one below and at the match value with the clear enable on and off, and write the compare value before and after an overflow, which exposes a shadow that loads too early. Same-cycle write against capture and clear against set show the priority rules.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    typedef enum logic [1:0] {
        SRC_PIN  = 2'b00,
        SRC_AUX0 = 2'b01,
        SRC_AUX1 = 2'b10,
        SRC_CMP  = 2'b11
    } trig_src_e;

    localparam int EDGE_FALL_BIT = 0;
    localparam int EDGE_RISE_BIT = 1;
endpackage

// File: rtl/tcc_edge_filt.sv
module tcc_edge_filt (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       edge_hit
);
    import tcc_pkg::*;

    typedef struct packed {
        logic s1;
        logic s2;
        logic level;
    } filt_t;

    filt_t st_d, st_q;
    logic  settled;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = pin;
        st_d.s2  = st_q.s1;
        settled  = (st_q.s1 == st_q.s2) && (st_q.s2 != st_q.level);
        if (settled) begin
            st_d.level = st_q.s2;
        end
        edge_hit = settled &&
                   (( st_q.s2 && edge_sel[EDGE_RISE_BIT]) ||
                    (!st_q.s2 && edge_sel[EDGE_FALL_BIT]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tcc_trig_sel.sv
module tcc_trig_sel (
    input  logic [1:0] trig_sel,
    input  logic       pin_hit,
    input  logic       aux0_ovf,
    input  logic       aux1_ovf,
    input  logic       cmp_evt,
    output logic       trig
);
    import tcc_pkg::*;

    always_comb begin
        unique case (trig_src_e'(trig_sel))
            SRC_PIN:  trig = pin_hit;
            SRC_AUX0: trig = aux0_ovf;
            SRC_AUX1: trig = aux1_ovf;
            SRC_CMP:  trig = cmp_evt;
            default:  trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] timer_cnt,
    input  logic             timer_dir,
    input  logic             timer_dual,
    input  logic             timer_ovf,
    input  logic             cap_pin,
    input  logic             aux0_ovf,
    input  logic             aux1_ovf,
    input  logic             cmp_evt,
    input  logic             mode_cmp,
    input  logic [1:0]       trig_sel,
    input  logic [1:0]       edge_sel,
    input  logic             clr_en,
    input  logic             irq_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] data_out,
    output logic             dir_out,
    output logic             flag,
    output logic             irq,
    output logic             timer_clr_req
);
    typedef struct packed {
        logic [CNT_W-1:0] data;
        logic [CNT_W-1:0] shadow;
        logic             dir;
        logic             flag;
    } chan_t;

    chan_t st_d, st_q;
    logic  pin_hit;
    logic  trig;
    logic  cap_evt;
    logic  match;

    tcc_edge_filt u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .edge_sel (edge_sel),
        .edge_hit (pin_hit)
    );

    tcc_trig_sel u_sel (
        .trig_sel (trig_sel),
        .pin_hit  (pin_hit),
        .aux0_ovf (aux0_ovf),
        .aux1_ovf (aux1_ovf),
        .cmp_evt  (cmp_evt),
        .trig     (trig)
    );

    always_comb begin
        st_d    = st_q;
        cap_evt = !mode_cmp && trig;
        match   = mode_cmp && (st_q.data == timer_cnt);

        if (wr_en) begin
            st_d.shadow = wr_data;
        end

        if (cap_evt) begin
            st_d.data = timer_cnt;
            st_d.dir  = timer_dual ? timer_dir : 1'b0;
        end else if (!mode_cmp && wr_en) begin
            st_d.data = wr_data;
        end else if (mode_cmp && timer_ovf) begin
            st_d.data = st_q.shadow;
        end

        if (cap_evt || match) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out      = st_q.data;
    assign dir_out       = st_q.dir;
    assign flag          = st_q.flag;
    assign irq           = st_q.flag && irq_en;
    assign timer_clr_req = match && clr_en;
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_cmp,
    input logic             timer_ovf,
    input logic [CNT_W-1:0] timer_cnt,
    input logic             flag_clr,
    input logic             cap_evt,
    input logic [CNT_W-1:0] data_out,
    input logic             flag,
    input logic             irq,
    input logic             timer_clr_req
);
    a_r4_capture_copies: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (flag && data_out == $past(timer_cnt)));

    a_r8_clear_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clr_req |=> flag);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    a_r11_active_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cmp && !timer_ovf) |=> $stable(data_out));
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_cmp      (mode_cmp),
    .timer_ovf     (timer_ovf),
    .timer_cnt     (timer_cnt),
    .flag_clr      (flag_clr),
    .cap_evt       (cap_evt),
    .data_out      (data_out),
    .flag          (flag),
    .irq           (irq),
    .timer_clr_req (timer_clr_req)
);

// File: tb/tcc_channel_test.sv
module tcc_channel_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_cnt = '0;
    logic        timer_dir = 1'b0, timer_dual = 1'b0, timer_ovf = 1'b0;
    logic        cap_pin = 1'b0, aux0_ovf = 1'b0, aux1_ovf = 1'b0, cmp_evt = 1'b0;
    logic        mode_cmp = 1'b0;
    logic [1:0]  trig_sel = 2'b00, edge_sel = 2'b00;
    logic        clr_en = 1'b0, irq_en = 1'b0, wr_en = 1'b0, flag_clr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] data_out;
    logic        dir_out, flag, irq, timer_clr_req;

    int checks = 0;
    int errors = 0;

    tcc_channel uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        cycles(1);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 reset flag", 16'(flag), 16'h0);
        check("R10 reset irq", 16'(irq), 16'h0);
        check("R4 reset data", data_out, 16'h0);
        check("R8 reset clr", 16'(timer_clr_req), 16'h0);
    endtask

    task automatic t_pin_rise();
        trig_sel = 2'b00; edge_sel = 2'b10; timer_cnt = 16'h1234;
        cap_pin = 1'b1;
        cycles(2);
        check("R1 not yet captured", data_out, 16'h0000);
        cycles(1);
        check("R1 rise captured", data_out, 16'h1234);
        check("R4 flag after capture", 16'(flag), 16'h1);
        clear_flag();
    endtask

    task automatic t_glitch();
        cap_pin = 1'b0;
        cycles(4);
        check("R2 falling ignored under rising", 16'(flag), 16'h0);
        timer_cnt = 16'h4321;
        cap_pin = 1'b1;
        cycles(1);
        cap_pin = 1'b0;
        cycles(4);
        check("R1 glitch ignored flag", 16'(flag), 16'h0);
        check("R1 glitch ignored data", data_out, 16'h1234);
    endtask

    task automatic t_fall();
        edge_sel = 2'b01; timer_cnt = 16'h00AB;
        cap_pin = 1'b1;
        cycles(4);
        check("R2 rising ignored under falling", 16'(flag), 16'h0);
        cap_pin = 1'b0;
        cycles(3);
        check("R2 falling captured", data_out, 16'h00AB);
        edge_sel = 2'b00;
        clear_flag();
        cap_pin = 1'b1;
        cycles(4);
        check("R2 none selects nothing", 16'(flag), 16'h0);
        cap_pin = 1'b0;
        cycles(4);
    endtask

    task automatic t_sources();
        trig_sel = 2'b01; timer_cnt = 16'h5555; timer_dual = 1'b1; timer_dir = 1'b1;
        aux1_ovf = 1'b1; cmp_evt = 1'b1;
        cycles(1);
        aux1_ovf = 1'b0; cmp_evt = 1'b0;
        check("R3 unselected sources ignored", 16'(flag), 16'h0);
        aux0_ovf = 1'b1;
        cycles(1);
        aux0_ovf = 1'b0;
        check("R3 aux0 capture", data_out, 16'h5555);
        check("R5 down latched in dual", 16'(dir_out), 16'h1);
        trig_sel = 2'b11; timer_cnt = 16'h6666; timer_dual = 1'b0;
        cmp_evt = 1'b1;
        cycles(1);
        cmp_evt = 1'b0;
        check("R6 overwrite with flag set", data_out, 16'h6666);
        check("R5 dir zero outside dual", 16'(dir_out), 16'h0);
        trig_sel = 2'b10; timer_cnt = 16'h7777;
        aux1_ovf = 1'b1;
        cycles(1);
        aux1_ovf = 1'b0;
        check("R3 aux1 capture", data_out, 16'h7777);
        clear_flag();
    endtask

    task automatic t_prio();
        wr_en = 1'b1; wr_data = 16'h1111;
        cycles(1);
        wr_en = 1'b0;
        check("R12 direct write in capture", data_out, 16'h1111);
        wr_en = 1'b1; wr_data = 16'h2222; timer_cnt = 16'h3333; aux1_ovf = 1'b1;
        cycles(1);
        wr_en = 1'b0; aux1_ovf = 1'b0;
        check("R12 capture beats write", data_out, 16'h3333);
        clear_flag();
    endtask

    task automatic t_compare();
        timer_cnt = 16'h0000; mode_cmp = 1'b1;
        wr_en = 1'b1; wr_data = 16'h0040;
        cycles(1);
        wr_en = 1'b0;
        cycles(2);
        check("R11 active held before overflow", data_out, 16'h3333);
        timer_ovf = 1'b1;
        cycles(1);
        timer_ovf = 1'b0;
        check("R11 shadow loaded on overflow", data_out, 16'h0040);
        clr_en = 1'b1; timer_cnt = 16'h003F;
        #1;
        check("R8 no request off match", 16'(timer_clr_req), 16'h0);
        cycles(1);
        check("R7 no flag off match", 16'(flag), 16'h0);
        timer_cnt = 16'h0040;
        #1;
        check("R8 request on match", 16'(timer_clr_req), 16'h1);
        clr_en = 1'b0;
        #1;
        check("R8 no request when disabled", 16'(timer_clr_req), 16'h0);
        cycles(1);
        check("R7 flag on match", 16'(flag), 16'h1);
        check("R10 irq masked", 16'(irq), 16'h0);
        irq_en = 1'b1;
        #1;
        check("R10 irq enabled", 16'(irq), 16'h1);
    endtask

    task automatic t_flag();
        flag_clr = 1'b1;
        cycles(1);
        flag_clr = 1'b0;
        check("R9 set wins over clear", 16'(flag), 16'h1);
        timer_cnt = 16'h0100;
        cycles(3);
        check("R9 flag sticky", 16'(flag), 16'h1);
        clear_flag();
        check("R9 flag cleared", 16'(flag), 16'h0);
        check("R10 irq follows flag", 16'(irq), 16'h0);
    endtask

    initial begin
        fork
            begin
                cycles(2);
                rst_n = 1'b1;
                cycles(1);
                t_reset();
                t_pin_rise();
                t_glitch();
                t_fall();
                t_sources();
                t_prio();
                t_compare();
                t_flag();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual timeout expected done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule